// File: doc/BRIEF.md
# Waveform Memory Playback Sequencer

The block walks a 1024-word by 32-bit waveform memory and presents one word after another to a downstream consumer. It generates the read address at a programmable pace, pulses a read strobe each time an address is issued, and raises a halted flag when a one-shot sweep has finished. The memory is a plain synchronous array with a single write port that an external loader fills before playback.

Two address windows are supplied as inputs. Window 0 and window 1 each carry a first address, a last address and a 16-bit step rate, which is the number of clock cycles each address is held. A 2-bit mode input selects one of four sweep styles. Playback is launched by a one-cycle update strobe. Once the block has been launched, each edge on the direction input restarts it. In bidirectional mode the level of the direction input also chooses between window 0, swept upward, and window 1, swept downward. Every window is expected to have its first address no greater than its last address.

Top module: `wavram_player`

## Requirements
- R1: While reset is high and in the first cycle after it, rd_addr is 0, rd_stb is 0 and halted is 1.
- R2: In the cycle after update_i is sampled high, rd_addr holds the starting address of the chosen window and rd_stb is 1. The starting address is window 1's last address in mode 01 with dir_i low, and window 0's first address in every other case.
- R3: After a start, the address advances once every R clock cycles, where R is the window's step rate. A rate of 0 behaves as 1. rd_stb is high for exactly one cycle with each new address.
- R4: Mode 00 (single ramp) counts up from window 0's first address to its last address. halted rises in the same cycle the last address appears, after which the address and strobe stay quiet.
- R5: Mode 01 (bidirectional), falling dir_i edge: playback loads window 1's last address, counts down at window 1's rate, and halts when it reaches window 1's first address.
- R6: Mode 01, rising dir_i edge: playback loads window 0's first address, restarts the step timer, counts up, and halts at window 0's last address.
- R7: Mode 11 (recirculate) counts up and returns from the last address to the first address. It never halts.
- R8: Mode 10 (continuous sweep) counts up to the last address and then down to the first address, repeating indefinitely. Each endpoint is held for one interval per turn, and it never halts.
- R9: When a window's first and last addresses are equal, that single address is held. The one-shot modes 00 and 01 report halted at once.
- R10: Edges on dir_i have no effect until the first update strobe after reset. After that strobe, in modes 00, 10 and 11, an edge restarts playback from window 0's first address.
- R11: rd_data presents, one cycle late, the memory word at the address rd_addr held in the previous cycle. That word is the last value written there through wr_en, wr_addr and wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Memory write enable |
| wr_addr | input | 10 | Memory write address |
| wr_data | input | 32 | Memory write data |
| seg0_first | input | 10 | Window 0 first address |
| seg0_last | input | 10 | Window 0 last address |
| seg0_rate | input | 16 | Window 0 cycles per address |
| seg1_first | input | 10 | Window 1 first address |
| seg1_last | input | 10 | Window 1 last address |
| seg1_rate | input | 16 | Window 1 cycles per address |
| play_mode | input | 2 | 00 ramp, 01 bidirectional, 10 continuous sweep, 11 recirculate |
| update_i | input | 1 | Start strobe, also latches the mode |
| dir_i | input | 1 | Direction / window select input |
| rd_addr | output | 10 | Current read address |
| rd_stb | output | 1 | One-cycle pulse per issued address |
| rd_data | output | 32 | Word read from memory, one cycle behind rd_addr |
| halted | output | 1 | One-shot sweep finished or never started |

## Verification
Several properties are checked on every cycle:
- a halted sequencer issues no strobe and keeps its address;
- the address never changes without a strobe;
- two steps are never adjacent when the rate exceeds one;
- the continuous modes stay inside their window and never halt;
- an update is always followed by a strobe;
- an unarmed block ignores the direction input.

Only the bench scenarios can show the exact address order and the hold length per address. The same holds for the turning points of the continuous sweep, the switch to window 1 on a falling edge, the zero-rate substitution, and the data returned for each address. The bench checks these against a cycle model built from the requirements, under directed and seeded random mode, window and direction patterns.

// File: rtl/wavram_pkg.sv
`timescale 1ns/1ps
package wavram_pkg;
  typedef enum logic [1:0] {
    PM_RAMP   = 2'b00,
    PM_BIDIR  = 2'b01,
    PM_CSWEEP = 2'b10,
    PM_RECIRC = 2'b11
  } play_mode_e;
endpackage

// File: rtl/wavram_mem.sv
`timescale 1ns/1ps
module wavram_mem #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/wavram_step_timer.sv
`timescale 1ns/1ps
module wavram_step_timer #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          run,
  input  logic [RW-1:0] rate_in,
  output logic          step
);
  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0] rate_q;
  logic [RW-1:0] cnt;
  logic [RW-1:0] rate_eff;

  assign rate_eff = (rate_in == '0) ? ONE : rate_in;
  assign step     = run && !restart && (cnt == rate_q - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= ONE;
      cnt    <= '0;
    end else begin
      if (restart) rate_q <= rate_eff;
      if (restart || !run || step) cnt <= '0;
      else                         cnt <= cnt + ONE;
    end
  end

  // R3: with a hold longer than one cycle, steps are never back to back
  p_step_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (step && rate_q > ONE) |=> !step);
endmodule

// File: rtl/wavram_seq.sv
`timescale 1ns/1ps
module wavram_seq
  import wavram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_up,
  input  logic [AW-1:0] ld_lo,
  input  logic [AW-1:0] ld_hi,
  input  play_mode_e    ld_mode,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          stb,
  output logic          halted
);
  localparam logic [AW-1:0] A1 = AW'(1);

  logic [AW-1:0] lo, hi, nxt_addr;
  logic          up, nxt_up, nxt_halt, ld_halt, ld_oneshot;
  play_mode_e    mode;

  assign ld_oneshot = (ld_mode == PM_RAMP) || (ld_mode == PM_BIDIR);
  assign ld_halt    = ld_oneshot && (ld_addr == (ld_up ? ld_hi : ld_lo));

  always_comb begin
    nxt_addr = addr;
    nxt_up   = up;
    nxt_halt = halted;
    unique case (mode)
      PM_RAMP, PM_BIDIR: begin
        nxt_addr = up ? addr + A1 : addr - A1;
        nxt_halt = (nxt_addr == (up ? hi : lo));
      end
      PM_RECIRC: nxt_addr = (addr == hi) ? lo : addr + A1;
      PM_CSWEEP: begin
        if (lo != hi) begin
          if (up) begin
            if (addr == hi) begin nxt_up = 1'b0; nxt_addr = addr - A1; end
            else            nxt_addr = addr + A1;
          end else begin
            if (addr == lo) begin nxt_up = 1'b1; nxt_addr = addr + A1; end
            else            nxt_addr = addr - A1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      up     <= 1'b1;
      lo     <= '0;
      hi     <= '0;
      mode   <= PM_RAMP;
      stb    <= 1'b0;
      halted <= 1'b1;
    end else if (start) begin
      addr   <= ld_addr;
      up     <= ld_up;
      lo     <= ld_lo;
      hi     <= ld_hi;
      mode   <= ld_mode;
      stb    <= 1'b1;
      halted <= ld_halt;
    end else if (step && !halted) begin
      addr   <= nxt_addr;
      up     <= nxt_up;
      halted <= nxt_halt;
      stb    <= 1'b1;
    end else begin
      stb    <= 1'b0;
    end
  end

  // R4: a finished sweep stays quiet until restarted
  p_quiet_halted_r4: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> (!stb && addr == $past(addr)));

  // R3: every address change is announced by the strobe
  p_move_strobed_r3: assert property (@(posedge clk) disable iff (rst)
    (addr != $past(addr)) |-> stb);

  // R7 / R8: continuous modes remain inside their window
  p_cont_window_r7: assert property (@(posedge clk) disable iff (rst)
    (!halted && (mode == PM_CSWEEP || mode == PM_RECIRC) && lo <= hi)
      |-> (addr >= lo && addr <= hi));

  // R8: continuous modes never report halted
  p_cont_runs_r8: assert property (@(posedge clk) disable iff (rst)
    (!halted && !start && (mode == PM_CSWEEP || mode == PM_RECIRC)) |=> !halted);
endmodule

// File: rtl/wavram_player.sv
`timescale 1ns/1ps
module wavram_player
  import wavram_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] seg0_first,
  input  logic [AW-1:0] seg0_last,
  input  logic [RW-1:0] seg0_rate,
  input  logic [AW-1:0] seg1_first,
  input  logic [AW-1:0] seg1_last,
  input  logic [RW-1:0] seg1_rate,
  input  logic [1:0]    play_mode,
  input  logic          update_i,
  input  logic          dir_i,
  output logic [AW-1:0] rd_addr,
  output logic          rd_stb,
  output logic [DW-1:0] rd_data,
  output logic          halted
);
  logic       dir_q, armed, start, use_w1, step;
  play_mode_e mode_q, eff_mode;

  always_ff @(posedge clk) dir_q <= dir_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      mode_q <= PM_RAMP;
    end else if (update_i) begin
      armed  <= 1'b1;
      mode_q <= play_mode_e'(play_mode);
    end
  end

  assign start    = update_i || (armed && (dir_i != dir_q));
  assign eff_mode = update_i ? play_mode_e'(play_mode) : mode_q;
  assign use_w1   = (eff_mode == PM_BIDIR) && !dir_i;

  wavram_step_timer #(.RW(RW)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .run     (!halted),
    .rate_in (use_w1 ? seg1_rate : seg0_rate),
    .step    (step)
  );

  wavram_seq #(.AW(AW)) seq_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ld_addr (use_w1 ? seg1_last  : seg0_first),
    .ld_up   (!use_w1),
    .ld_lo   (use_w1 ? seg1_first : seg0_first),
    .ld_hi   (use_w1 ? seg1_last  : seg0_last),
    .ld_mode (eff_mode),
    .step    (step),
    .addr    (rd_addr),
    .stb     (rd_stb),
    .halted  (halted)
  );

  wavram_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R2: an update strobe always issues an address next cycle
  p_update_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    update_i |=> rd_stb);

  // R10: before the first update, direction edges start nothing
  p_unarmed_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!armed && !update_i) |=> (!rd_stb && halted));
endmodule

// File: tb/wavram_player_tb.sv
`timescale 1ns/1ps
module wavram_player_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [9:0]  s0_first = '0, s0_last = '0, s1_first = '0, s1_last = '0;
  logic [15:0] s0_rate = '0, s1_rate = '0;
  logic [1:0]  pmode = '0;
  logic        upd = 1'b0, dir = 1'b0;
  logic [9:0]  rd_addr;
  logic        rd_stb, halted;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  wavram_player dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .seg0_first(s0_first), .seg0_last(s0_last), .seg0_rate(s0_rate),
    .seg1_first(s1_first), .seg1_last(s1_last), .seg1_rate(s1_rate),
    .play_mode(pmode), .update_i(upd), .dir_i(dir),
    .rd_addr(rd_addr), .rd_stb(rd_stb), .rd_data(rd_data), .halted(halted)
  );

  // cycle model built from the requirements
  logic [31:0] mem_m [1024];
  logic [9:0]  m_addr, m_lo, m_hi;
  logic [15:0] m_rate, m_cnt;
  logic [1:0]  m_mode, m_modeq;
  logic        m_stb, m_halt, m_up, m_armed, m_dirq, mem_ok = 1'b0;
  logic [31:0] m_data;

  function automatic logic [31:0] pattern(input int i);
    return 32'hA5A5_0000 ^ (i * 32'h0100_0193);
  endfunction

  task automatic model_edge();
    logic rise, fall, start, step, w1;
    logic [1:0]  em;
    logic [15:0] r;
    m_data = mem_m[m_addr];                       // R11: one-cycle-late data
    if (rst) begin
      m_addr = '0; m_stb = 0; m_halt = 1; m_up = 1; m_armed = 0; m_modeq = 0;
      m_cnt = '0; m_rate = 16'd1; m_dirq = dir; m_mode = 0; m_lo = '0; m_hi = '0;
      return;
    end
    rise  = dir && !m_dirq;
    fall  = !dir && m_dirq;
    start = upd || (m_armed && (rise || fall));
    em    = upd ? pmode : m_modeq;
    step  = !m_halt && !start && (m_cnt == m_rate - 16'd1);
    m_dirq = dir;
    if (start || m_halt || step) m_cnt = '0; else m_cnt = m_cnt + 16'd1;
    if (upd) begin m_armed = 1; m_modeq = pmode; end
    if (start) begin
      w1     = (em == 2'b01) && !dir;
      m_mode = em;
      m_up   = !w1;
      m_lo   = w1 ? s1_first : s0_first;
      m_hi   = w1 ? s1_last  : s0_last;
      m_addr = w1 ? s1_last  : s0_first;
      r      = w1 ? s1_rate  : s0_rate;
      m_rate = (r == 0) ? 16'd1 : r;
      m_halt = (em <= 2'b01) && (m_addr == (m_up ? m_hi : m_lo));
      m_stb  = 1;
    end else if (step) begin
      m_stb = 1;
      case (m_mode)
        2'b00, 2'b01: begin
          m_addr = m_up ? m_addr + 10'd1 : m_addr - 10'd1;
          m_halt = (m_addr == (m_up ? m_hi : m_lo));
        end
        2'b11: m_addr = (m_addr == m_hi) ? m_lo : m_addr + 10'd1;
        default: if (m_lo != m_hi) begin
          if (m_up) begin
            if (m_addr == m_hi) begin m_up = 0; m_addr = m_addr - 10'd1; end
            else m_addr = m_addr + 10'd1;
          end else begin
            if (m_addr == m_lo) begin m_up = 1; m_addr = m_addr + 10'd1; end
            else m_addr = m_addr - 10'd1;
          end
        end
      endcase
    end else begin
      m_stb = 0;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (rd_addr !== m_addr || rd_stb !== m_stb || halted !== m_halt ||
        (mem_ok && rd_data !== m_data)) begin
      fails++;
      $display("FAIL %s: addr/stb/halt/data actual %0d/%0b/%0b/%h expected %0d/%0b/%0b/%h",
               tag, rd_addr, rd_stb, halted, rd_data, m_addr, m_stb, m_halt, m_data);
    end
  endtask

  task automatic expect_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit chk = 1'b1);
    @(posedge clk);
    model_edge();
    #1;
    if (chk) compare(tag);
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic launch(input string tag);
    upd = 1'b1;
    cyc(tag);
    upd = 1'b0;
  endtask

  task automatic set_w0(input int f, input int l, input int r);
    s0_first = 10'(f); s0_last = 10'(l); s0_rate = 16'(r);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    @(negedge clk);
    cyc("R1", 1'b0); cyc("R1", 1'b0);
    expect_val("R1 addr", rd_addr, 0);
    expect_val("R1 stb", rd_stb, 0);
    expect_val("R1 halted", halted, 1);
    rst = 1'b0;
    cyc("R1");
    expect_val("R1 halted after reset", halted, 1);

    // fill memory
    wr_en = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      wr_addr = 10'(i); wr_data = pattern(i); mem_m[i] = pattern(i);
      cyc("load", 1'b0);
    end
    wr_en = 1'b0;
    cyc("load", 1'b0);
    mem_ok = 1'b1;

    // R4 single ramp, rate 3
    pmode = 2'b00; set_w0(5, 9, 3);
    launch("R2");
    expect_val("R2 start addr", rd_addr, 5);
    run("R4", 25);
    expect_val("R4 end addr", rd_addr, 9);
    expect_val("R4 halted", halted, 1);
    cyc("R11");
    expect_val("R11 data", rd_data, pattern(9));

    // R3 rate 0 acts as 1
    set_w0(5, 12, 0);
    launch("R3");
    expect_val("R3 addr0", rd_addr, 5);
    cyc("R3"); expect_val("R3 addr1", rd_addr, 6);
    cyc("R3"); expect_val("R3 addr2", rd_addr, 7);
    run("R3", 10);

    // R6 / R5 bidirectional
    pmode = 2'b01; set_w0(10, 14, 2);
    s1_first = 10'd20; s1_last = 10'd23; s1_rate = 16'd1;
    dir = 1'b1; cyc("R6"); cyc("R6");
    launch("R6");
    expect_val("R6 start", rd_addr, 10);
    run("R6", 15);
    expect_val("R6 end", rd_addr, 14);
    expect_val("R6 halted", halted, 1);
    dir = 1'b0;
    cyc("R5");
    expect_val("R5 load last", rd_addr, 23);
    run("R5", 10);
    expect_val("R5 end", rd_addr, 20);
    expect_val("R5 halted", halted, 1);
    dir = 1'b1;
    cyc("R6");
    expect_val("R6 restart", rd_addr, 10);
    run("R6", 4);

    // R8 continuous sweep
    pmode = 2'b10; set_w0(30, 33, 1);
    launch("R8");
    run("R8", 20);
    expect_val("R8 running", halted, 0);

    // R7 recirculate
    pmode = 2'b11; set_w0(40, 42, 2);
    launch("R7");
    run("R7", 20);
    expect_val("R7 running", halted, 0);

    // R10 direction edge restarts recirculate
    dir = ~dir;
    cyc("R10");
    expect_val("R10 restart addr", rd_addr, 40);
    expect_val("R10 restart stb", rd_stb, 1);
    run("R10", 6);

    // R9 single-address windows
    pmode = 2'b00; set_w0(50, 50, 2);
    launch("R9");
    expect_val("R9 ramp addr", rd_addr, 50);
    expect_val("R9 ramp halted", halted, 1);
    run("R9", 4);
    pmode = 2'b11;
    launch("R9");
    run("R9", 8);
    expect_val("R9 recirc addr", rd_addr, 50);
    expect_val("R9 recirc halted", halted, 0);

    // R10 edges before the first update are ignored
    rst = 1'b1; cyc("R1", 1'b0); cyc("R1", 1'b0); rst = 1'b0;
    for (int i = 0; i < 6; i++) begin dir = ~dir; cyc("R10"); end
    expect_val("R10 idle stb", rd_stb, 0);
    expect_val("R10 idle halted", halted, 1);

    // seeded random mix
    for (int t = 0; t < 40; t++) begin
      int f0, f1;
      f0 = int'($urandom % 1000); f1 = int'($urandom % 1000);
      set_w0(f0, f0 + int'($urandom % 6), int'($urandom % 4));
      s1_first = 10'(f1); s1_last = 10'(f1 + int'($urandom % 6));
      s1_rate  = 16'($urandom % 4);
      pmode = 2'($urandom % 4);
      dir   = 1'($urandom % 2);
      cyc("RND");
      launch("RND");
      for (int c = 0; c < 25; c++) begin
        if ($urandom % 10 == 0) dir = ~dir;
        cyc("RND");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule